// File: doc/BRIEF.md
# Dual-Mode Transition and Recovery Controller

This block chooses between the two operating modes of a small serial configuration memory. In the stream mode the memory pushes its contents out bit by bit, paced by a separate stream clock. In the bidirectional mode a bus master talks to the memory over a two-wire serial bus. The block does not decode the serial protocol and does not move any data. It owns the mode decision, and it tells the stream transmitter and the serial slave which of them may act.

After reset the block is in stream mode. The first filtered falling edge on the bus clock puts it into a transitional bidirectional state. In that state it counts rising edges of the stream clock while the bus is idle, which means both bus lines are high and stable. Any falling edge on the bus clock clears the count. If the count reaches 128, the block returns to stream mode and sends a one-cycle restart pulse, so that the transmitter starts again at address zero with the most significant bit first.

If the serial slave reports that the device was addressed correctly while the block is in the transitional state, the block locks into bidirectional mode. It stays there, ignoring the stream clock, until the next reset. All three line inputs are sampled in the block clock domain. A level change is accepted only after it has held for a set number of samples, so short glitches cannot change the mode.

Top module: `dualmode_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycles after it is released, `mode_bidir_o`, `slave_en_o` and `restart_o` are all 0. Encoding: `mode_bidir_o` = 0 means stream mode and 1 means bidirectional.
- R2: In stream mode, a falling edge of the filtered bus clock sets `mode_bidir_o` to 1.
- R3: While the bus clock stays high, the block stays in stream mode, however many stream-clock pulses arrive.
- R4: In the transitional state, a rising edge of the stream clock is counted only if the bus clock and bus data are both high. Pulses that arrive while either line is low are not counted.
- R5: On the 128th counted pulse, `mode_bidir_o` returns to 0, and `restart_o` is high for exactly one cycle. The count then starts again from zero.
- R6: A filtered falling edge of the bus clock in the transitional state clears the pulse count. After it, a full 128 further idle pulses are needed before the block reverts.
- R7: An `addr_hit_i` pulse in the transitional state locks the block in bidirectional mode. Stream-clock pulses and bus-clock edges then have no effect, and only reset leaves this state.
- R8: A low excursion of the bus clock that lasts fewer than `FILT_LEN` block-clock samples is ignored. It neither switches the mode nor clears the count.
- R9: `slave_en_o` is 1 exactly when `mode_bidir_o` is 1.
- R10: An `addr_hit_i` pulse in stream mode is ignored, and the block stays in stream mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; all three line inputs are sampled on it |
| rst_ni | input | 1 | Asynchronous active-low reset, standing in for power-up |
| scl_i | input | 1 | Bus clock level, already synchronized |
| sda_i | input | 1 | Bus data level, already synchronized |
| sclk_i | input | 1 | Stream clock level, already synchronized |
| addr_hit_i | input | 1 | One-cycle pulse from the serial slave when the device has been validly addressed |
| mode_bidir_o | output | 1 | 1 in bidirectional mode (transitional or locked), 0 in stream mode |
| restart_o | output | 1 | One-cycle pulse: the stream transmitter restarts at address zero, MSB first |
| slave_en_o | output | 1 | Enable for the serial slave |

## Verification
The assertions take two things for granted about the inputs:
- Every input is a clean level in the block clock domain.
- `addr_hit_i` is a single-cycle pulse.

They also assume that stream-clock pulses are spaced widely enough for the filter to see each high and low phase. The bench holds every stream-clock phase for four block cycles, which is longer than the filter length. It asserts `addr_hit_i` for one cycle only, and it changes a bus line only while the other lines are steady. The only exception is the deliberate one-sample glitch used for R8.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [1:0] {
    MODE_TXO   = 2'd0,
    MODE_TRANS = 2'd1,
    MODE_LOCK  = 2'd2
  } mode_e;

  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;
  localparam int unsigned LINE_SCLK = 2;
  localparam int unsigned NUM_LINES = 3;
endpackage

// File: rtl/dm_rst_sync.sv
module dm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/dm_line_filter.sv
module dm_line_filter #(
  parameter int unsigned FILT_LEN = 2,
  parameter logic        RST_VAL  = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  output logic lvl_o,
  output logic chg_o
);
  logic [FILT_LEN-1:0] hist_q, hist_d;
  logic                lvl_q, lvl_d;
  logic                chg_q, chg_d;

  always_comb begin
    hist_d = {hist_q[FILT_LEN-2:0], din_i};
    lvl_d  = lvl_q;
    if (&hist_q)  lvl_d = 1'b1;
    if (~|hist_q) lvl_d = 1'b0;
    chg_d  = (lvl_d != lvl_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= {FILT_LEN{RST_VAL}};
      lvl_q  <= RST_VAL;
      chg_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      lvl_q  <= lvl_d;
      chg_q  <= chg_d;
    end
  end

  assign lvl_o = lvl_q;
  assign chg_o = chg_q;
endmodule

// File: rtl/dm_sat_counter.sv
module dm_sat_counter #(
  parameter int unsigned LIMIT = 128,
  parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_LIM = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr_i | (inc_i & (cnt_q != CNT_MAX));
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
  assign hit_o = (cnt_q == CNT_LIM);
endmodule

// File: rtl/dm_mode_fsm.sv
module dm_mode_fsm
  import dm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_lvl_i,
  input  logic  scl_chg_i,
  input  logic  sda_lvl_i,
  input  logic  sda_chg_i,
  input  logic  sclk_lvl_i,
  input  logic  sclk_chg_i,
  input  logic  addr_hit_i,
  input  logic  cnt_hit_i,
  output logic  cnt_clr_o,
  output logic  cnt_inc_o,
  output mode_e state_o,
  output logic  restart_o
);
  mode_e state_q, state_d;
  logic  restart_q, restart_d;
  logic  scl_fall, sclk_rise, bus_idle;

  assign scl_fall  = scl_chg_i & ~scl_lvl_i;
  assign sclk_rise = sclk_chg_i & sclk_lvl_i;
  assign bus_idle  = scl_lvl_i & sda_lvl_i & ~sda_chg_i;

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    unique case (state_q)
      MODE_TXO: begin
        if (scl_fall) state_d = MODE_TRANS;
      end
      MODE_TRANS: begin
        if (addr_hit_i) begin
          state_d = MODE_LOCK;
        end else if (cnt_hit_i && !scl_fall) begin
          state_d   = MODE_TXO;
          restart_d = 1'b1;
        end
      end
      MODE_LOCK: state_d = MODE_LOCK;
      default:   state_d = MODE_TXO;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= MODE_TXO;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      restart_q <= restart_d;
    end
  end

  assign cnt_clr_o = (state_q != MODE_TRANS) | scl_fall | cnt_hit_i;
  assign cnt_inc_o = (state_q == MODE_TRANS) & sclk_rise & bus_idle;
  assign state_o   = state_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/dualmode_ctrl.sv
module dualmode_ctrl
  import dm_pkg::*;
#(
  parameter int unsigned FILT_LEN      = 2,
  parameter int unsigned REVERT_PULSES = 128,
  parameter int unsigned RST_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic sclk_i,
  input  logic addr_hit_i,
  output logic mode_bidir_o,
  output logic restart_o,
  output logic slave_en_o
);
  localparam int unsigned CNT_W = $clog2(REVERT_PULSES + 1);
  localparam logic [NUM_LINES-1:0] LINE_RST = 3'b011;

  logic                 rst_sync_n;
  logic [NUM_LINES-1:0] line_raw, line_lvl, line_chg;
  logic [CNT_W-1:0]     cnt;
  logic                 cnt_hit, cnt_clr, cnt_inc;
  mode_e                state;
  logic                 lock_st;

  dm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  assign line_raw[LINE_SCL]  = scl_i;
  assign line_raw[LINE_SDA]  = sda_i;
  assign line_raw[LINE_SCLK] = sclk_i;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    dm_line_filter #(
      .FILT_LEN(FILT_LEN),
      .RST_VAL (LINE_RST[g])
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_sync_n),
      .din_i (line_raw[g]),
      .lvl_o (line_lvl[g]),
      .chg_o (line_chg[g])
    );
  end

  dm_sat_counter #(.LIMIT(REVERT_PULSES), .CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt),
    .hit_o (cnt_hit)
  );

  dm_mode_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .scl_lvl_i (line_lvl[LINE_SCL]),
    .scl_chg_i (line_chg[LINE_SCL]),
    .sda_lvl_i (line_lvl[LINE_SDA]),
    .sda_chg_i (line_chg[LINE_SDA]),
    .sclk_lvl_i(line_lvl[LINE_SCLK]),
    .sclk_chg_i(line_chg[LINE_SCLK]),
    .addr_hit_i(addr_hit_i),
    .cnt_hit_i (cnt_hit),
    .cnt_clr_o (cnt_clr),
    .cnt_inc_o (cnt_inc),
    .state_o   (state),
    .restart_o (restart_o)
  );

  assign lock_st      = (state == MODE_LOCK);
  assign mode_bidir_o = (state != MODE_TXO);
  assign slave_en_o   = (state != MODE_TXO);
endmodule

// File: rtl/dualmode_ctrl_chk.sv
module dualmode_ctrl_chk #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned LIMIT = 128
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_bidir,
  input logic             restart,
  input logic             scl_lvl,
  input logic             locked,
  input logic [CNT_W-1:0] cnt
);
  // R1: outputs idle while reset is held
  p_reset_txo_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!mode_bidir && !restart));

  // R3: a high bus clock keeps stream mode
  p_scl_high_stays_txo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_bidir && scl_lvl) |=> !mode_bidir);

  // R4: the count never passes the revert threshold
  p_count_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CNT_W'(LIMIT));

  // R5: restart lasts one cycle
  p_restart_one_cycle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> !restart);

  // R5: restart comes only with a revert out of bidirectional mode
  p_restart_on_revert_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |-> (!mode_bidir && $past(mode_bidir)));

  // R7: the locked state is permanent
  p_lock_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> (locked && mode_bidir && !restart));
endmodule

bind dualmode_ctrl dualmode_ctrl_chk #(
  .CNT_W(CNT_W),
  .LIMIT(REVERT_PULSES)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_sync_n),
  .mode_bidir(mode_bidir_o),
  .restart   (restart_o),
  .scl_lvl   (line_lvl[0]),
  .locked    (lock_st),
  .cnt       (cnt)
);

// File: tb/dualmode_ctrl_tb.sv
module dualmode_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;
  localparam logic [2:0] OP_IDLE = 3'd0, OP_SFALL = 3'd1, OP_GLITCH = 3'd2,
                         OP_ADDR = 3'd3, OP_SCLLO = 3'd4, OP_SDALO = 3'd5;

  // {op, pulse count, expected mode, expected restarts, requirement}
  typedef struct packed {
    logic [2:0] op;
    logic [7:0] n;
    logic       mode;
    logic [3:0] rs;
    logic [3:0] req;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{OP_ADDR,   8'd0,   1'b0, 4'd0, 4'd10}, // R10 address pulse ignored in stream mode
    '{OP_IDLE,   8'd5,   1'b0, 4'd0, 4'd3},  // R3
    '{OP_GLITCH, 8'd0,   1'b0, 4'd0, 4'd8},  // R8
    '{OP_SFALL,  8'd0,   1'b1, 4'd0, 4'd2},  // R2
    '{OP_IDLE,   8'd127, 1'b1, 4'd0, 4'd4},  // R4
    '{OP_IDLE,   8'd1,   1'b0, 4'd1, 4'd5},  // R5
    '{OP_SFALL,  8'd0,   1'b1, 4'd1, 4'd2},  // R2
    '{OP_IDLE,   8'd100, 1'b1, 4'd1, 4'd6},  // R6
    '{OP_SFALL,  8'd0,   1'b1, 4'd1, 4'd6},  // R6 count cleared
    '{OP_IDLE,   8'd127, 1'b1, 4'd1, 4'd6},  // R6
    '{OP_IDLE,   8'd1,   1'b0, 4'd2, 4'd5},  // R5
    '{OP_SFALL,  8'd0,   1'b1, 4'd2, 4'd2},  // R2
    '{OP_SCLLO,  8'd200, 1'b1, 4'd2, 4'd4},  // R4 bus clock low
    '{OP_SDALO,  8'd200, 1'b1, 4'd2, 4'd4},  // R4 bus data low
    '{OP_IDLE,   8'd127, 1'b1, 4'd2, 4'd4},  // R4
    '{OP_GLITCH, 8'd0,   1'b1, 4'd2, 4'd8},  // R8 count not cleared
    '{OP_IDLE,   8'd1,   1'b0, 4'd3, 4'd8},  // R8
    '{OP_SFALL,  8'd0,   1'b1, 4'd3, 4'd2},  // R2
    '{OP_ADDR,   8'd0,   1'b1, 4'd3, 4'd7},  // R7
    '{OP_IDLE,   8'd200, 1'b1, 4'd3, 4'd7},  // R7
    '{OP_SFALL,  8'd0,   1'b1, 4'd3, 4'd7}   // R7
  };

  logic clk = 1'b0;
  logic rst_n, scl, sda, sclk, addr_hit;
  logic mode_bidir, restart, slave_en;
  int   checks = 0, errors = 0, restarts = 0, wide_rs = 0;
  logic rs_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dualmode_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .scl_i       (scl),
    .sda_i       (sda),
    .sclk_i      (sclk),
    .addr_hit_i  (addr_hit),
    .mode_bidir_o(mode_bidir),
    .restart_o   (restart),
    .slave_en_o  (slave_en)
  );

  always @(negedge clk) begin
    if (restart) restarts <= restarts + 1;
    if (restart && rs_prev) wide_rs <= wide_rs + 1;
    rs_prev <= restart;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1; wait_cyc(4);
      sclk = 1'b0; wait_cyc(4);
    end
  endtask

  task automatic run_op(input vec_t v);
    case (v.op)
      OP_IDLE:   pulses(int'(v.n));
      OP_SFALL:  begin scl = 1'b0; wait_cyc(6); scl = 1'b1; end
      OP_GLITCH: begin scl = 1'b0; wait_cyc(1); scl = 1'b1; end
      OP_ADDR:   begin addr_hit = 1'b1; wait_cyc(1); addr_hit = 1'b0; end
      OP_SCLLO:  begin scl = 1'b0; wait_cyc(6); pulses(int'(v.n)); scl = 1'b1; end
      OP_SDALO:  begin sda = 1'b0; wait_cyc(6); pulses(int'(v.n)); sda = 1'b1; end
      default:   ;
    endcase
    wait_cyc(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; scl = 1'b1; sda = 1'b1; sclk = 1'b0; addr_hit = 1'b0;
    wait_cyc(3);
    @(negedge clk);
    check("R1 mode in reset", 32'(mode_bidir), 0);
    check("R1 enable in reset", 32'(slave_en), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    check("R1 mode after reset", 32'(mode_bidir), 0);
    check("R1 restart after reset", 32'(restarts), 0);

    for (int i = 0; i < NV; i++) begin
      run_op(VEC[i]);
      @(negedge clk);
      check($sformatf("R%0d row %0d mode", VEC[i].req, i), 32'(mode_bidir), 32'(VEC[i].mode));
      check($sformatf("R9 row %0d slave enable", i), 32'(slave_en), 32'(VEC[i].mode));
      check($sformatf("R%0d row %0d restarts", VEC[i].req, i), 32'(restarts), 32'(VEC[i].rs));
    end
    check("R5 restart width", 32'(wide_rs), 0);

    // R1: reset leaves the locked state
    rst_n = 1'b0;
    wait_cyc(2);
    @(negedge clk);
    check("R1 reset from lock mode", 32'(mode_bidir), 0);
    check("R1 reset from lock enable", 32'(slave_en), 0);
    rst_n = 1'b1;
    wait_cyc(5);
    // R2 after a fresh reset, then R5 revert once more
    run_op('{OP_SFALL, 8'd0, 1'b1, 4'd3, 4'd2});
    @(negedge clk);
    check("R2 switch after reset", 32'(mode_bidir), 1);
    pulses(128);
    wait_cyc(12);
    @(negedge clk);
    check("R5 revert after reset", 32'(mode_bidir), 0);
    check("R5 restart count", 32'(restarts), 4);
    check("R5 restart width final", 32'(wide_rs), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule